// File: doc/BRIEF.md
# Multi-Speed SCL Phase Timer

This block times the clock line of an I2C master. A two-bit speed selector picks one of three programmable pairs of high and low counts: standard, fast or high speed. The block pulls SCL low for the low phase and then releases it. It waits until the filtered line actually reads high, then times the high phase. The high phase is stretched by a fixed overhead and by the active spike-filter length. The low phase gets one extra cycle.

Both sampled bus lines, SCL and SDA, pass through a programmable glitch filter before anything uses their level. The byte engine sits beside this block. It receives a launch strobe on the first cycle of every low phase, where it may change SDA. It receives a sample strobe in the middle of every high phase, where it may read SDA. Converting a target bus frequency into counts is done elsewhere, and so is the byte-level protocol.

The inputs `scl_in` and `sda_in` are assumed to be synchronised to `clk` already.

Top module: `scl_phase_timer`

## Requirements
- R1: `mode` selects the count pair: 0 selects the standard pair, 1 the fast pair and 2 the high-speed pair. The value 3 behaves exactly like 0.
- R2: Each low phase holds `scl_pull_low` at 1 for the selected low count + 1 cycles. `launch_stb` is 1 on the first of those cycles only.
- R3: The high phase lasts selected high count + active spike length + 7 cycles. It begins on the cycle after the filtered SCL is seen high at a clock edge. So with a direct loop from the pin, the released time is H + max(S,1) + 1 cycles, where H is the high-phase length and S the active spike length.
- R4: The active spike length S is `fast_spike` in modes 0, 1 and 3, and `hs_spike` in mode 2. It applies to both line filters.
- R5: A filtered line takes a new raw level only after that level has been sampled on max(S,1) consecutive clock edges. Shorter pulses never reach `scl_clean` or `sda_clean`.
- R6: `sample_stb` is 1 for one cycle, on high-phase cycle index floor(H/2), counted from 0. It is never 1 together with `launch_stb`.
- R7: A device that holds SCL low after release delays the start of the high phase by the time it holds the line. The released time grows by the same number of cycles.
- R8: With `run` at 0 the block leaves SCL released. Setting `run` starts a low phase. Clearing `run` lets the current phase finish, after which SCL stays released and no strobe appears.
- R9: While `rst_n` is 0 at a clock edge, SCL is released, both strobes are 0 and both filtered lines read 1.
- R10: The count of a phase is captured when the phase starts. Changing the count registers during a phase does not change that phase's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Enables clock generation |
| mode | input | 2 | Speed selector (0 standard, 1 fast, 2 high speed, 3 as 0) |
| std_hcnt | input | CNT_W | Standard-mode high count |
| std_lcnt | input | CNT_W | Standard-mode low count |
| fast_hcnt | input | CNT_W | Fast-mode high count |
| fast_lcnt | input | CNT_W | Fast-mode low count |
| hs_hcnt | input | CNT_W | High-speed high count |
| hs_lcnt | input | CNT_W | High-speed low count |
| fast_spike | input | SPK_W | Spike length for standard and fast modes |
| hs_spike | input | SPK_W | Spike length for high-speed mode |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| scl_pull_low | output | 1 | 1 = drive SCL low |
| scl_clean | output | 1 | Filtered SCL |
| sda_clean | output | 1 | Filtered SDA |
| launch_stb | output | 1 | First cycle of a low phase |
| sample_stb | output | 1 | Middle of a high phase |

## Verification
The hardest case to reach is a device stretching the clock. The high-phase timer must keep waiting while the line it released stays low, and must absorb the filter delay before it starts counting. The bench closes SCL in a loop from the pull output back to the input through a hold term. It raises that term on the first released cycle and keeps it for a vector-chosen number of cycles. The measured released time and the sample-strobe position then show the wait, the filter delay and the high count all at once. Count changes during a phase and clearing `run` during a low phase are driven on the first low cycle, seen through the launch strobe.

// File: rtl/scl_timer_pkg.sv
// Shared constants and types for the SCL phase timer.
package scl_timer_pkg;
    localparam int DEF_CNT_W = 16;
    localparam int DEF_SPK_W = 8;
    localparam int HIGH_OVERHEAD = 7;

    typedef enum logic [1:0] {
        SPEED_STD  = 2'd0,
        SPEED_FAST = 2'd1,
        SPEED_HS   = 2'd2,
        SPEED_ALT  = 2'd3
    } speed_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOW    = 2'd1,
        PH_WAIT   = 2'd2,
        PH_HIGH   = 2'd3
    } phase_t;
endpackage

// File: rtl/scl_glitch_filter.sv
// Glitch filter for one bus line.
// Passes a new raw level only after it has been sampled on max(spk_len,1)
// consecutive edges. Assumes raw is already synchronous to clk.
module scl_glitch_filter #(
    parameter int SPK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPK_W-1:0] spk_len,
    input  logic             raw,
    output logic             clean
);
    logic [SPK_W-1:0] diff_run;
    logic [SPK_W:0]   diff_next;

    // Length the current run of differing samples would reach this edge.
    assign diff_next = {1'b0, diff_run} + 1'b1;

    // Count differing samples and flip the output once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean    <= 1'b1;
            diff_run <= '0;
        end else if (raw == clean) begin
            diff_run <= '0;
        end else if (diff_next >= {1'b0, spk_len}) begin
            clean    <= raw;
            diff_run <= '0;
        end else begin
            diff_run <= diff_next[SPK_W-1:0];
        end
    end

    // R5: the output only ever moves to the level sampled at that edge.
    assert_follows_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> (clean == $past(raw)));
endmodule

// File: rtl/scl_mode_select.sv
// Speed-mode multiplexer.
// Picks the high count, low count and spike length for the selected mode.
// Mode 3 is treated as standard; standard shares the fast spike length.
module scl_mode_select
    import scl_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SPK_W = 8
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] std_hcnt,
    input  logic [CNT_W-1:0] std_lcnt,
    input  logic [CNT_W-1:0] fast_hcnt,
    input  logic [CNT_W-1:0] fast_lcnt,
    input  logic [CNT_W-1:0] hs_hcnt,
    input  logic [CNT_W-1:0] hs_lcnt,
    input  logic [SPK_W-1:0] fast_spike,
    input  logic [SPK_W-1:0] hs_spike,
    output logic [CNT_W-1:0] hcnt_sel,
    output logic [CNT_W-1:0] lcnt_sel,
    output logic [SPK_W-1:0] spk_sel
);
    // Route the register pair of the chosen speed.
    always_comb begin
        unique case (speed_t'(mode))
            SPEED_FAST: begin
                hcnt_sel = fast_hcnt;
                lcnt_sel = fast_lcnt;
                spk_sel  = fast_spike;
            end
            SPEED_HS: begin
                hcnt_sel = hs_hcnt;
                lcnt_sel = hs_lcnt;
                spk_sel  = hs_spike;
            end
            default: begin
                hcnt_sel = std_hcnt;
                lcnt_sel = std_lcnt;
                spk_sel  = fast_spike;
            end
        endcase
    end
endmodule

// File: rtl/scl_phase_engine.sv
// Phase sequencer for SCL.
// Drives the low phase for lcnt+1 cycles, waits for filtered SCL high,
// then times hcnt+spk+7 cycles. Counts are captured at phase start.
module scl_phase_engine
    import scl_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SPK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] lcnt,
    input  logic [SPK_W-1:0] spk,
    input  logic             scl_filt,
    output logic             scl_pull_low,
    output logic             launch_stb,
    output logic             sample_stb
);
    localparam int TW = CNT_W + 1;

    phase_t        phase;
    logic [TW-1:0] tick;
    logic [TW-1:0] low_last;
    logic [TW-1:0] high_len;
    logic [TW-1:0] high_len_now;

    // Total high-phase length for the currently selected registers.
    assign high_len_now = TW'(hcnt) + TW'(spk) + TW'(HIGH_OVERHEAD);

    // Advance through idle, low, wait-for-high and high phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            tick     <= '0;
            low_last <= '0;
            high_len <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (run) begin
                        phase    <= PH_LOW;
                        tick     <= '0;
                        low_last <= TW'(lcnt);
                    end
                end
                PH_LOW: begin
                    if (tick == low_last) begin
                        phase <= run ? PH_WAIT : PH_IDLE;
                        tick  <= '0;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (scl_filt) begin
                        phase    <= PH_HIGH;
                        tick     <= '0;
                        high_len <= high_len_now;
                    end
                end
                PH_HIGH: begin
                    if (tick == high_len - 1'b1) begin
                        tick <= '0;
                        if (run) begin
                            phase    <= PH_LOW;
                            low_last <= TW'(lcnt);
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decode the line drive and the two strobes from the phase state.
    always_comb begin
        scl_pull_low = (phase == PH_LOW);
        launch_stb   = (phase == PH_LOW) && (tick == '0);
        sample_stb   = (phase == PH_HIGH) && (tick == (high_len >> 1));
    end

    // R3: the high phase is entered only after filtered SCL was seen high.
    assert_high_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH && $past(phase) == PH_WAIT) |-> $past(scl_filt));

    // R2: the low-phase counter never passes its captured end value.
    assert_low_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |-> (tick <= low_last));

    // R6: launch and sample strobes never coincide.
    assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({launch_stb, sample_stb}));

    // R8: a low phase only begins when run was set at that edge.
    assert_low_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> $past(run));
endmodule

// File: rtl/scl_phase_timer.sv
// Top of the multi-speed SCL phase timer.
// Filters both bus lines, selects the speed registers and sequences SCL.
// Assumes scl_in and sda_in are already synchronous to clk.
module scl_phase_timer
    import scl_timer_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int SPK_W = DEF_SPK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] std_hcnt,
    input  logic [CNT_W-1:0] std_lcnt,
    input  logic [CNT_W-1:0] fast_hcnt,
    input  logic [CNT_W-1:0] fast_lcnt,
    input  logic [CNT_W-1:0] hs_hcnt,
    input  logic [CNT_W-1:0] hs_lcnt,
    input  logic [SPK_W-1:0] fast_spike,
    input  logic [SPK_W-1:0] hs_spike,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_pull_low,
    output logic             scl_clean,
    output logic             sda_clean,
    output logic             launch_stb,
    output logic             sample_stb
);
    localparam int N_LINES = 2;

    logic [CNT_W-1:0]   hcnt_sel;
    logic [CNT_W-1:0]   lcnt_sel;
    logic [SPK_W-1:0]   spk_sel;
    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_clean;

    // Bundle the lines so one filter instance is built per line.
    assign line_raw  = {sda_in, scl_in};
    assign scl_clean = line_clean[0];
    assign sda_clean = line_clean[1];

    scl_mode_select #(.CNT_W(CNT_W), .SPK_W(SPK_W)) u_sel (
        .mode       (mode),
        .std_hcnt   (std_hcnt),
        .std_lcnt   (std_lcnt),
        .fast_hcnt  (fast_hcnt),
        .fast_lcnt  (fast_lcnt),
        .hs_hcnt    (hs_hcnt),
        .hs_lcnt    (hs_lcnt),
        .fast_spike (fast_spike),
        .hs_spike   (hs_spike),
        .hcnt_sel   (hcnt_sel),
        .lcnt_sel   (lcnt_sel),
        .spk_sel    (spk_sel)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        scl_glitch_filter #(.SPK_W(SPK_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .spk_len (spk_sel),
            .raw     (line_raw[g]),
            .clean   (line_clean[g])
        );
    end

    scl_phase_engine #(.CNT_W(CNT_W), .SPK_W(SPK_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .hcnt         (hcnt_sel),
        .lcnt         (lcnt_sel),
        .spk          (spk_sel),
        .scl_filt     (line_clean[0]),
        .scl_pull_low (scl_pull_low),
        .launch_stb   (launch_stb),
        .sample_stb   (sample_stb)
    );
endmodule

// File: tb/sim_scl_phase_timer.sv
`timescale 1ns/1ps
module sim_scl_phase_timer;
    localparam int CNT_W = 16;
    localparam int SPK_W = 8;
    localparam int NVEC  = 6;
    localparam logic [15:0] JUNK_CNT = 16'd500;
    localparam logic [7:0]  JUNK_SPK = 8'd200;

    // {mode, high count, low count, spike length, stretch cycles}
    localparam logic [49:0] VECS [NVEC] = '{
        {2'd0, 16'd10, 16'd8,  8'd2, 8'd0},
        {2'd1, 16'd5,  16'd3,  8'd0, 8'd0},
        {2'd2, 16'd3,  16'd1,  8'd1, 8'd0},
        {2'd3, 16'd12, 16'd6,  8'd3, 8'd0},
        {2'd1, 16'd0,  16'd6,  8'd5, 8'd4},
        {2'd2, 16'd20, 16'd15, 8'd9, 8'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [CNT_W-1:0] std_hcnt = '0, std_lcnt = '0, fast_hcnt = '0;
    logic [CNT_W-1:0] fast_lcnt = '0, hs_hcnt = '0, hs_lcnt = '0;
    logic [SPK_W-1:0] fast_spike = '0, hs_spike = '0;
    logic hold_low = 1'b0;
    logic sda_in = 1'b1;
    logic scl_in;
    logic scl_pull_low, scl_clean, sda_clean, launch_stb, sample_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Open-drain loop: the pin is low when driven or held by a device.
    assign scl_in = ~scl_pull_low & ~hold_low;

    scl_phase_timer #(.CNT_W(CNT_W), .SPK_W(SPK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
        .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
        .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
        .hs_hcnt(hs_hcnt), .hs_lcnt(hs_lcnt),
        .fast_spike(fast_spike), .hs_spike(hs_spike),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull_low(scl_pull_low), .scl_clean(scl_clean), .sda_clean(sda_clean),
        .launch_stb(launch_stb), .sample_stb(sample_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measure one full SCL period starting from the next low phase.
    task automatic measure(input int stretch, output int lo_len, output int rel_len,
                           output int samp_at, output int launch_seen);
        int guard;
        guard = 0;
        while (!scl_pull_low && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        launch_seen = launch_stb;
        lo_len = 0;
        while (scl_pull_low && lo_len < 3000) begin
            lo_len++;
            @(negedge clk);
        end
        rel_len = 0;
        samp_at = -1;
        if (stretch > 0) hold_low = 1'b1;
        while (!scl_pull_low && rel_len < 3000) begin
            if (sample_stb) samp_at = rel_len;
            if (launch_stb) samp_at = -2;
            rel_len++;
            @(negedge clk);
            if (rel_len == stretch) hold_low = 1'b0;
        end
    endtask

    initial begin
        int lo, rel, smp, lau, s_eff, h_len, cnt;
        logic [49:0] v;
        string tag;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 pull", scl_pull_low, 0);
        check("R9 launch", launch_stb, 0);
        check("R9 sample", sample_stb, 0);
        check("R9 scl_clean", scl_clean, 1);
        check("R9 sda_clean", sda_clean, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 idle released", scl_pull_low, 0);

        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            mode = v[49:48];
            std_hcnt = JUNK_CNT; std_lcnt = JUNK_CNT;
            fast_hcnt = JUNK_CNT; fast_lcnt = JUNK_CNT;
            hs_hcnt = JUNK_CNT; hs_lcnt = JUNK_CNT;
            fast_spike = JUNK_SPK; hs_spike = JUNK_SPK;
            case (v[49:48])
                2'd1: begin fast_hcnt = v[47:32]; fast_lcnt = v[31:16]; end
                2'd2: begin hs_hcnt = v[47:32]; hs_lcnt = v[31:16]; end
                default: begin std_hcnt = v[47:32]; std_lcnt = v[31:16]; end
            endcase
            if (v[49:48] == 2'd2) hs_spike = v[15:8];
            else fast_spike = v[15:8];
            s_eff = (v[15:8] == 0) ? 1 : int'(v[15:8]);
            h_len = int'(v[47:32]) + int'(v[15:8]) + 7;
            run = 1'b1;
            measure(int'(v[7:0]), lo, rel, smp, lau);
            tag = (v[7:0] != 0) ? "R7" : "R3";
            check($sformatf("R2 vec%0d launch", i), lau, 1);
            check($sformatf("R1 R2 vec%0d low length", i), lo, int'(v[31:16]) + 1);
            check($sformatf("R1 R4 %s vec%0d released length", tag, i), rel,
                  int'(v[7:0]) + s_eff + 1 + h_len);
            check($sformatf("R6 vec%0d sample index", i), smp,
                  int'(v[7:0]) + s_eff + 1 + h_len / 2);
            check($sformatf("R2 vec%0d next launch", i), launch_stb, 1);
            run = 1'b0;
            repeat (300) @(negedge clk);
        end

        // R8 and R10: clear run and change the count on the first low cycle.
        mode = 2'd0; std_hcnt = 16'd4; std_lcnt = 16'd10; fast_spike = 8'd2;
        run = 1'b1;
        cnt = 0;
        while (!scl_pull_low && cnt < 100) begin @(negedge clk); cnt++; end
        std_lcnt = 16'd2;
        run = 1'b0;
        lo = 0;
        while (scl_pull_low && lo < 100) begin lo++; @(negedge clk); end
        check("R10 captured low length", lo, 11);
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            if (scl_pull_low || launch_stb || sample_stb) cnt++;
            @(negedge clk);
        end
        check("R8 stays released after run cleared", cnt, 0);

        // R4 R5: filters in standard mode use the fast spike length (4).
        mode = 2'd0; fast_spike = 8'd4; hs_spike = 8'd2;
        repeat (5) @(negedge clk);
        sda_in = 1'b0;
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 2) sda_in = 1'b1;
            if (!sda_clean) cnt++;
        end
        check("R4 R5 three-cycle pulse suppressed", cnt, 0);
        sda_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 not yet passed after three", sda_clean, 1);
        @(negedge clk);
        check("R5 four-cycle level passed", sda_clean, 0);
        sda_in = 1'b1;
        repeat (10) @(negedge clk);
        mode = 2'd2;
        repeat (3) @(negedge clk);
        sda_in = 1'b0;
        @(negedge clk);
        check("R4 hs not yet after one", sda_clean, 1);
        @(negedge clk);
        check("R4 hs spike length two", sda_clean, 0);
        sda_in = 1'b1;
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule